// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of hardware lock flags shared by two independent access ports, called left and right. Software running on two processors uses them to claim and hand back a shared resource without any other agreement between the two sides. Each port has its own strobes: a semaphore select, a memory select that must stay inactive during semaphore traffic, a read/write line, an output enable, a flag address and a data bus. Both ports are sampled on one common clock.

A write with data bit 0 at 0 asks for a flag. A write with bit 0 at 1 gives it back. If the other port holds the flag, the request waits. It is granted on the clock edge at which the holder lets go. When both ports ask for the same free flag in one cycle, the left port wins and the right request waits. A read returns the flag's status on every data bit: 0 means "held by me" and 1 means "not held by me". If a port drives its semaphore select and its memory select active at the same time, it gets no semaphore action and a conflict flag instead.

Top module: `dual_sem_unit`

## Requirements
- R1: There are eight flags, selected by the 3-bit address of each port. An operation on one flag never changes any other flag.
- R2: A port acts only when its semaphore select is low and its memory select is high. A write needs rw low. A read needs rw high and output enable low. With the semaphore select high, a write has no effect.
- R3: A write uses only data bit 0 (0 = request, 1 = release). Bits 7..1 do not change the result.
- R4: Read data is registered and appears in the cycle after the read is presented. Every data bit carries 8'h00 if the reading port owns the flag and 8'hFF otherwise, so the non-owner always reads 8'hFF.
- R5: A request to a free flag makes the requesting port its owner at that clock edge.
- R6: A request to a flag held by the other port stays pending. It is granted on the edge at which the holder releases.
- R7: A release frees the flag only when written by its owner. A release by the non-owner leaves the owner unchanged and cancels the non-owner's own pending request.
- R8: When both ports request the same free flag in the same cycle, the left port becomes owner and the right request stays pending.
- R9: When a port drives its semaphore select and its memory select low together, that port does no read or write. Its conflict output is high in the following cycle.
- R10: After reset all flags are free, nothing is pending, and the read-valid, read-data and conflict outputs are 0.
- R11: In any cycle that follows no read access, the port's read-valid output is 0 and its read data is 8'h00. This models a released bus.
- R12: The two ports operate independently. Both may act on different flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_mem_ce_n | input | 1 | Left memory select, active low; must be high for semaphore access |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left flag address |
| l_wdata | input | 8 | Left write data, bit 0 used |
| l_rdata | output | 8 | Left read data |
| l_rdata_oe | output | 1 | Left read data valid / drive enable |
| l_conflict | output | 1 | Left illegal-select indication |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_mem_ce_n | input | 1 | Right memory select, active low; must be high for semaphore access |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right flag address |
| r_wdata | input | 8 | Right write data, bit 0 used |
| r_rdata | output | 8 | Right read data |
| r_rdata_oe | output | 1 | Right read data valid / drive enable |
| r_conflict | output | 1 | Right illegal-select indication |

## Verification
Two situations can land on one clock edge. In the first, a request meets another request: both ports write 0 to the same free flag in the same cycle, and afterwards the left port must read 8'h00 while the right port reads 8'hFF. In the second, a release meets a pending request: the owner's release and the hand-over to the waiting port happen on one edge, so the waiting port must read 8'h00 on its very next access with no extra retry. A separate scenario also has both ports write different flags in one cycle. Each side's view is then read back to confirm that neither write disturbed the other.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OWN_FREE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;
endpackage

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
   import sem_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l_req,
   input  logic l_rel,
   input  logic r_req,
   input  logic r_rel,
   output logic own_l,
   output logic own_r
);
   owner_e owner_q, owner_d;
   logic   pl_q, pr_q, pl_d, pr_d;
   logic   held_l, held_r, keep_l, keep_r, want_l, want_r, free_n, gnt_l, gnt_r;

   always_comb begin
      held_l = (owner_q == OWN_LEFT);
      held_r = (owner_q == OWN_RIGHT);
      keep_l = held_l & ~l_rel;
      keep_r = held_r & ~r_rel;
      want_l = (pl_q | (l_req & ~held_l)) & ~l_rel;
      want_r = (pr_q | (r_req & ~held_r)) & ~r_rel;
      free_n = ~keep_l & ~keep_r;
   end

   generate
      if (TIE_LEFT) begin : g_tie_left
         assign gnt_l = free_n & want_l;
         assign gnt_r = free_n & want_r & ~want_l;
      end else begin : g_tie_right
         assign gnt_r = free_n & want_r;
         assign gnt_l = free_n & want_l & ~want_r;
      end
   endgenerate

   always_comb begin
      if (keep_l)      owner_d = OWN_LEFT;
      else if (keep_r) owner_d = OWN_RIGHT;
      else if (gnt_l)  owner_d = OWN_LEFT;
      else if (gnt_r)  owner_d = OWN_RIGHT;
      else             owner_d = OWN_FREE;
      pl_d = want_l & ~gnt_l;
      pr_d = want_r & ~gnt_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_FREE;
         pl_q    <= 1'b0;
         pr_q    <= 1'b0;
      end else begin
         owner_q <= owner_d;
         pl_q    <= pl_d;
         pr_q    <= pr_d;
      end
   end

   assign own_l = (owner_q == OWN_LEFT);
   assign own_r = (owner_q == OWN_RIGHT);

   // a waiting request exists only while the other side holds the flag
   assert_left_wait_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pl_q |-> (owner_q == OWN_RIGHT));
   assert_right_wait_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pr_q |-> (owner_q == OWN_LEFT));
   assert_handover_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_RIGHT && pl_q && r_rel && !l_rel) |=> (owner_q == OWN_LEFT));
   assert_foreign_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_RIGHT && l_rel && !r_rel) |=> (owner_q == OWN_RIGHT && !pl_q));
   assert_free_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_FREE && !pl_q && !pr_q && l_req && !r_req) |=> (owner_q == OWN_LEFT));

   generate
      if (TIE_LEFT) begin : g_tie_chk
         assert_tie_to_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_q == OWN_FREE && !pl_q && !pr_q && l_req && r_req) |=> (owner_q == OWN_LEFT && pr_q));
      end
   endgenerate
endmodule

// File: rtl/sem_port.sv
module sem_port #(
   parameter int NUM_FLAGS = 8,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sem_n,
   input  logic                 mem_ce_n,
   input  logic                 rw,
   input  logic                 oe_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_FLAGS-1:0] own_vec,
   output logic [NUM_FLAGS-1:0] req_vec,
   output logic [NUM_FLAGS-1:0] rel_vec,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rdata_oe,
   output logic                 conflict
);
   logic sel, illegal, wr_en, rd_en;
   logic unused_wdata;

   assign sel          = ~sem_n & mem_ce_n;
   assign illegal      = ~sem_n & ~mem_ce_n;
   assign wr_en        = sel & ~rw;
   assign rd_en        = sel & rw & ~oe_n;
   assign unused_wdata = ^wdata;

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
         assign req_vec[i] = wr_en & (addr == ADDR_W'(i)) & ~wdata[0];
         assign rel_vec[i] = wr_en & (addr == ADDR_W'(i)) &  wdata[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rdata_oe <= 1'b0;
         conflict <= 1'b0;
      end else begin
         rdata    <= rd_en ? {DATA_W{~own_vec[addr]}} : '0;
         rdata_oe <= rd_en;
         conflict <= illegal;
      end
   end

   assert_status_on_all_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (rdata == '0 || rdata == '1));
   assert_bus_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == '0));
   assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> (conflict && !rdata_oe));
   assert_no_strobe_when_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (req_vec == '0 && rel_vec == '0));
endmodule

// File: rtl/dual_sem_unit.sv
module dual_sem_unit #(
   parameter int NUM_FLAGS = 8,
   parameter int DATA_W    = 8,
   parameter bit TIE_LEFT  = 1'b1,
   parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sem_n,
   input  logic              l_mem_ce_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rdata_oe,
   output logic              l_conflict,
   input  logic              r_sem_n,
   input  logic              r_mem_ce_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rdata_oe,
   output logic              r_conflict
);
   generate
      if (NUM_FLAGS < 2 || NUM_FLAGS != (1 << ADDR_W)) begin : g_bad_flags
         $error("NUM_FLAGS must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] own_l, own_r;
   logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;

   sem_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_left (
      .clk(clk), .rst_n(rst_n), .sem_n(l_sem_n), .mem_ce_n(l_mem_ce_n), .rw(l_rw),
      .oe_n(l_oe_n), .addr(l_addr), .wdata(l_wdata), .own_vec(own_l),
      .req_vec(l_req), .rel_vec(l_rel), .rdata(l_rdata), .rdata_oe(l_rdata_oe),
      .conflict(l_conflict)
   );

   sem_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_right (
      .clk(clk), .rst_n(rst_n), .sem_n(r_sem_n), .mem_ce_n(r_mem_ce_n), .rw(r_rw),
      .oe_n(r_oe_n), .addr(r_addr), .wdata(r_wdata), .own_vec(own_r),
      .req_vec(r_req), .rel_vec(r_rel), .rdata(r_rdata), .rdata_oe(r_rdata_oe),
      .conflict(r_conflict)
   );

   generate
      for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
         sem_flag_cell #(.TIE_LEFT(TIE_LEFT)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[f]), .l_rel(l_rel[f]),
            .r_req(r_req[f]), .r_rel(r_rel[f]),
            .own_l(own_l[f]), .own_r(own_r[f])
         );
      end
   endgenerate

   // an illegal select on one side, with the other side silent, leaves every flag alone
   assert_illegal_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sem_n && !l_mem_ce_n && r_req == '0 && r_rel == '0) |=> ($stable(own_l) && $stable(own_r)));
   // at most one owner per flag
   assert_single_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l & own_r) == '0);
endmodule

// File: tb/tb_dual_sem_unit.sv
`timescale 1ns/100ps
module tb_dual_sem_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_sem_n, l_mem_ce_n, l_rw, l_oe_n;
   logic [2:0] l_addr;
   logic [7:0] l_wdata, l_rdata;
   logic       l_rdata_oe, l_conflict;
   logic       r_sem_n, r_mem_ce_n, r_rw, r_oe_n;
   logic [2:0] r_addr;
   logic [7:0] r_wdata, r_rdata;
   logic       r_rdata_oe, r_conflict;
   int         total = 0;
   int         bad = 0;

   always #2.5 clk = ~clk;

   dual_sem_unit dut (
      .clk(clk), .rst_n(rst_n),
      .l_sem_n(l_sem_n), .l_mem_ce_n(l_mem_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe),
      .l_conflict(l_conflict),
      .r_sem_n(r_sem_n), .r_mem_ce_n(r_mem_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe),
      .r_conflict(r_conflict)
   );

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_all();
      {l_sem_n, l_mem_ce_n, l_rw, l_oe_n} = 4'b1111; l_addr = '0; l_wdata = '0;
      {r_sem_n, r_mem_ce_n, r_rw, r_oe_n} = 4'b1111; r_addr = '0; r_wdata = '0;
   endtask

   task automatic drive(input bit side, input bit sem_n, input bit ce_n, input bit rw,
                        input bit oe_n, input logic [2:0] a, input logic [7:0] d);
      if (side == 1'b0) begin
         l_sem_n = sem_n; l_mem_ce_n = ce_n; l_rw = rw; l_oe_n = oe_n; l_addr = a; l_wdata = d;
      end else begin
         r_sem_n = sem_n; r_mem_ce_n = ce_n; r_rw = rw; r_oe_n = oe_n; r_addr = a; r_wdata = d;
      end
   endtask

   task automatic sem_write(input bit side, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); drive(side, 1'b0, 1'b1, 1'b0, 1'b1, a, d);
      @(negedge clk); idle_all();
   endtask

   task automatic expect_read(input bit side, input logic [2:0] a, input logic [7:0] exp, input string tag);
      logic [7:0] d;
      logic       v;
      @(negedge clk); drive(side, 1'b0, 1'b1, 1'b1, 1'b0, a, 8'h00);
      @(negedge clk);
      d = side ? r_rdata : l_rdata;
      v = side ? r_rdata_oe : l_rdata_oe;
      idle_all();
      chk(v == 1'b1, {tag, " read valid"}, {7'd0, v}, 8'h01);
      chk(d == exp, tag, d, exp);
   endtask

   task automatic t_reset();
      chk(l_rdata_oe == 1'b0 && r_rdata_oe == 1'b0, "R10 valid low", {6'd0, l_rdata_oe, r_rdata_oe}, 8'h00);
      chk(l_conflict == 1'b0 && r_conflict == 1'b0, "R10 conflict low", {6'd0, l_conflict, r_conflict}, 8'h00);
      chk(l_rdata == 8'h00 && r_rdata == 8'h00, "R10 rdata zero", l_rdata | r_rdata, 8'h00);
      for (int i = 0; i < 8; i++) expect_read(1'b0, 3'(i), 8'hFF, "R10 left flag free");
      expect_read(1'b1, 3'd0, 8'hFF, "R10 right flag free");
   endtask

   task automatic t_claim_and_wait();
      sem_write(1'b0, 3'd3, 8'h00);
      expect_read(1'b0, 3'd3, 8'h00, "R5 left owns");
      expect_read(1'b1, 3'd3, 8'hFF, "R4 other side reads ones");
      sem_write(1'b1, 3'd3, 8'h00);
      expect_read(1'b1, 3'd3, 8'hFF, "R6 right waits");
      expect_read(1'b0, 3'd3, 8'h00, "R6 left still owns");
      sem_write(1'b0, 3'd3, 8'h01);
      expect_read(1'b1, 3'd3, 8'h00, "R6 handover on release");
      expect_read(1'b0, 3'd3, 8'hFF, "R6 left lost flag");
      sem_write(1'b1, 3'd3, 8'h01);
      expect_read(1'b0, 3'd3, 8'hFF, "R7 owner release frees");
      expect_read(1'b1, 3'd3, 8'hFF, "R7 right freed");
   endtask

   task automatic t_bit0_only();
      sem_write(1'b0, 3'd5, 8'hFE);
      expect_read(1'b0, 3'd5, 8'h00, "R3 FE acts as request");
      sem_write(1'b0, 3'd5, 8'h01);
      expect_read(1'b0, 3'd5, 8'hFF, "R3 release frees");
      sem_write(1'b1, 3'd5, 8'h02);
      expect_read(1'b1, 3'd5, 8'h00, "R3 02 acts as request");
      sem_write(1'b1, 3'd5, 8'hFF);
      expect_read(1'b1, 3'd5, 8'hFF, "R3 FF acts as release");
   endtask

   task automatic t_foreign_release();
      sem_write(1'b0, 3'd4, 8'h00);
      sem_write(1'b1, 3'd4, 8'h00);
      sem_write(1'b1, 3'd4, 8'h01);
      expect_read(1'b0, 3'd4, 8'h00, "R7 owner kept after foreign release");
      sem_write(1'b0, 3'd4, 8'h01);
      expect_read(1'b1, 3'd4, 8'hFF, "R7 pending cancelled");
      expect_read(1'b0, 3'd4, 8'hFF, "R7 flag free");
      sem_write(1'b1, 3'd4, 8'h01);
      sem_write(1'b0, 3'd4, 8'h00);
      expect_read(1'b0, 3'd4, 8'h00, "R7 release on free flag harmless");
      sem_write(1'b0, 3'd4, 8'h01);
   endtask

   task automatic t_same_cycle_tie();
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd6, 8'h00);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd6, 8'h00);
      @(negedge clk); idle_all();
      expect_read(1'b0, 3'd6, 8'h00, "R8 left wins tie");
      expect_read(1'b1, 3'd6, 8'hFF, "R8 right not owner");
      sem_write(1'b0, 3'd6, 8'h01);
      expect_read(1'b1, 3'd6, 8'h00, "R8 right request kept pending");
      sem_write(1'b1, 3'd6, 8'h01);
   endtask

   task automatic t_independent();
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 8'h00);
      @(negedge clk); idle_all();
      expect_read(1'b0, 3'd1, 8'h00, "R12 left own flag");
      expect_read(1'b0, 3'd2, 8'hFF, "R12 left sees right flag");
      expect_read(1'b1, 3'd2, 8'h00, "R12 right own flag");
      expect_read(1'b1, 3'd1, 8'hFF, "R12 right sees left flag");
      expect_read(1'b0, 3'd3, 8'hFF, "R1 untouched flag free");
      sem_write(1'b0, 3'd1, 8'h01);
      sem_write(1'b1, 3'd2, 8'h01);
   endtask

   task automatic t_gating();
      @(negedge clk); drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
      @(negedge clk);
      chk(l_rdata_oe == 1'b0, "R11 no valid without output enable", {7'd0, l_rdata_oe}, 8'h00);
      chk(l_rdata == 8'h00, "R11 data released", l_rdata, 8'h00);
      idle_all();
      @(negedge clk); drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 8'h00);
      @(negedge clk); idle_all();
      chk(l_rdata_oe == 1'b0, "R2 no read response without select", {7'd0, l_rdata_oe}, 8'h00);
      expect_read(1'b0, 3'd0, 8'hFF, "R2 write without select ignored");
   endtask

   task automatic t_illegal();
      @(negedge clk); drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 8'h00);
      @(negedge clk);
      chk(l_conflict == 1'b1, "R9 conflict raised", {7'd0, l_conflict}, 8'h01);
      idle_all();
      @(negedge clk); drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 8'h00);
      @(negedge clk);
      chk(l_rdata_oe == 1'b0, "R9 no read on illegal select", {7'd0, l_rdata_oe}, 8'h00);
      idle_all();
      @(negedge clk);
      chk(l_conflict == 1'b0, "R9 conflict clears", {7'd0, l_conflict}, 8'h00);
      chk(r_conflict == 1'b0, "R9 other side unaffected", {7'd0, r_conflict}, 8'h00);
      expect_read(1'b0, 3'd7, 8'hFF, "R9 no claim from illegal write");
      expect_read(1'b1, 3'd7, 8'hFF, "R9 flag still free for right");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_claim_and_wait();
      t_bit0_only();
      t_foreign_release();
      t_same_cycle_tie();
      t_independent();
      t_gating();
      t_illegal();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule